// File: doc/BRIEF.md
# Serial EEPROM Read Emulator

This block stands in for a small serial EEPROM behind a register that a driver toggles by hand. Each register write carries a serial clock bit and a data-in bit. The block remembers the clock bit from the previous write. A write that takes that bit from 0 to 1 counts as one serial clock edge. On each edge the block does one of three things: it shifts a command bit in, it shifts an address bit in, or it drives the next reply bit onto its data-out bit.

Two commands are understood. A read takes an 8-bit byte address and returns one 16-bit word. The word is chosen by dropping the low bit of the byte address. A status read returns eight zero bits. Any other command stops the engine and sets a sticky error flag. A read whose word index falls outside the 64-word store does the same.

The store is cleared at reset, except that word 0 comes up holding 0xBABA. A direct preload port can write words before serial traffic starts.

Top module: `serial_rom_emu`

## Requirements
- R1: A serial edge is counted only on a write strobe whose clock bit is 1 while the clock bit of the previous write was 0. The remembered clock bit is 0 after reset. Writes that keep the clock at 1, or drop it to 0, advance nothing.
- R2: The first 8 edges of a command shift the data-in bit into an 8-bit command code, most significant bit first. The code 0x03 is a read and 0x05 is a status read.
- R3: After a read code, the next 8 edges take a byte address, most significant bit first. The 16 edges after that drive data-out with bits 15 down to 0 of word (address >> 1), so address bit 0 is ignored.
- R4: After a status code, the next 8 edges drive data-out to 0.
- R5: After the 16th data edge of a read, or the 8th reply edge of a status read, the code, the address and all bit counts clear. The next edge starts a new command.
- R6: Data-out is 0 after reset. It changes only on a counted edge and holds its value between edges.
- R7: After reset every word reads 0, except word 0, which reads 0xBABA.
- R8: When the 8th command bit completes a code other than 0x03 or 0x05, the error flag rises after that edge. It stays high until reset, and later edges change neither data-out nor any state.
- R9: On the first data edge of a read whose word index (address >> 1) is 64 or more, the error flag rises and data-out goes to 0. The engine then halts as in R8.
- R10: A cycle with the preload enable high writes the preload data into the addressed word. A later serial read of that word returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Control register write strobe |
| sck_bit | input | 1 | Serial clock bit carried by the write |
| sdi_bit | input | 1 | Serial data-in bit carried by the write |
| load_en | input | 1 | Preload write enable |
| load_idx | input | 6 | Preload word index |
| load_data | input | 16 | Preload word value |
| sdo_bit | output | 1 | Serial data-out bit |
| err_flag | output | 1 | Sticky protocol error flag |

## Verification
The assertions assume that a serial edge arrives only together with a write strobe. They also assume that the preload port is used only while no serial command is in progress, so a read never races a preload of the same word. The stimulus builds every serial bit as two writes, clock low then clock high. Redundant high-clock and falling-clock writes are added only at points where the bench expects them to be ignored. Preloads are issued only between commands. Random addresses are kept below 0x80, except in the directed out-of-range case, which is followed by a reset.

// File: rtl/srom_pkg.sv
package srom_pkg;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned STAT_W = 8;
  localparam logic [OP_W-1:0] OPC_READ = 8'h03;
  localparam logic [OP_W-1:0] OPC_STAT = 8'h05;
  localparam logic [15:0]     WORD0_INIT = 16'hBABA;

  // byte address to word index: low bit dropped
  function automatic logic [ADDR_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a >> 1;
  endfunction

  function automatic logic code_known(input logic [OP_W-1:0] op);
    return (op == OPC_READ) || (op == OPC_STAT);
  endfunction
endpackage

// File: rtl/srom_edge.sv
module srom_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic sck_bit,
  output logic rise
);
  logic prev_q;

  assign rise = wr_stb && sck_bit && !prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      prev_q <= 1'b0;
    else if (wr_stb) prev_q <= sck_bit;
  end

  AST_RISE_LEAVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> prev_q); // R1
  AST_NO_STB_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> !$rose(prev_q)); // R1
endmodule

// File: rtl/srom_store.sv
module srom_store #(
  parameter int unsigned WORDS  = 64,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  import srom_pkg::*;

  logic [WORD_W-1:0] mem_q [WORDS];

  assign rd_word = mem_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++)
        mem_q[i] <= (i == 0) ? WORD_W'(WORD0_INIT) : '0;
    end else if (ld_en) begin
      mem_q[ld_idx] <= ld_data;
    end
  end

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (mem_q[$past(ld_idx)] == $past(ld_data))); // R10
  AST_RESET_WORD0: assert property (@(posedge clk)
    $rose(rst_n) |-> (mem_q[0] == WORD_W'(WORD0_INIT))); // R7
endmodule

// File: rtl/srom_seq.sv
module srom_seq #(
  parameter int unsigned WORDS  = 64,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned DC_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              sdi,
  input  logic [WORD_W-1:0] rd_word,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              sdo,
  output logic              err
);
  import srom_pkg::*;

  localparam logic [DC_W-1:0] LAST_RD = DC_W'(WORD_W - 1);
  localparam logic [DC_W-1:0] LAST_ST = DC_W'(STAT_W - 1);

  logic [3:0]        op_cnt_q, adr_cnt_q;
  logic [DC_W-1:0]   dat_cnt_q;
  logic [OP_W-1:0]   opcode_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sdo_q, halt_q;

  logic              in_op, in_addr, in_rdata, in_stat, in_range, step;
  logic [OP_W-1:0]   op_nxt;
  logic [ADDR_W-1:0] widx;
  logic [DC_W-1:0]   bitpos;

  assign in_op    = op_cnt_q < 4'(OP_W);
  assign in_addr  = !in_op && (opcode_q == OPC_READ) && (adr_cnt_q < 4'(ADDR_W));
  assign in_rdata = !in_op && (opcode_q == OPC_READ) && (adr_cnt_q == 4'(ADDR_W));
  assign in_stat  = !in_op && (opcode_q == OPC_STAT);
  assign widx     = word_of(addr_q);
  assign in_range = 32'(widx) < WORDS;
  assign step     = rise && !halt_q;
  assign op_nxt   = {opcode_q[OP_W-2:0], sdi};
  assign bitpos   = LAST_RD - dat_cnt_q;
  assign rd_idx   = IDX_W'(widx);
  assign sdo      = sdo_q;
  assign err      = halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_cnt_q <= '0; adr_cnt_q <= '0; dat_cnt_q <= '0;
      opcode_q <= '0; addr_q <= '0; sdo_q <= 1'b0; halt_q <= 1'b0;
    end else if (step) begin
      if (in_op) begin
        opcode_q <= op_nxt;
        op_cnt_q <= op_cnt_q + 4'd1;
        if (op_cnt_q == 4'(OP_W - 1) && !code_known(op_nxt)) halt_q <= 1'b1;
      end else if (in_addr) begin
        addr_q    <= {addr_q[ADDR_W-2:0], sdi};
        adr_cnt_q <= adr_cnt_q + 4'd1;
      end else if (in_rdata) begin
        if (!in_range) begin
          halt_q <= 1'b1;
          sdo_q  <= 1'b0;
        end else begin
          sdo_q <= rd_word[bitpos];
          if (dat_cnt_q == LAST_RD) begin
            op_cnt_q <= '0; adr_cnt_q <= '0; dat_cnt_q <= '0;
            opcode_q <= '0; addr_q <= '0;
          end else begin
            dat_cnt_q <= dat_cnt_q + 1'b1;
          end
        end
      end else if (in_stat) begin
        sdo_q <= 1'b0;
        if (dat_cnt_q == LAST_ST) begin
          op_cnt_q <= '0; adr_cnt_q <= '0; dat_cnt_q <= '0;
          opcode_q <= '0; addr_q <= '0;
        end else begin
          dat_cnt_q <= dat_cnt_q + 1'b1;
        end
      end
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable({op_cnt_q, adr_cnt_q, dat_cnt_q, opcode_q, addr_q})); // R1
  AST_OP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    op_cnt_q <= 4'(OP_W)); // R2
  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    adr_cnt_q <= 4'(ADDR_W)); // R3
  AST_STAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && in_stat) |=> !sdo_q); // R4
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && in_rdata && in_range && dat_cnt_q == LAST_RD) |=> (op_cnt_q == 4'd0)); // R5
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(sdo_q)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q); // R8
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> $stable(sdo_q)); // R8
  AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && in_rdata && !in_range) |=> (halt_q && !sdo_q)); // R9
endmodule

// File: rtl/serial_rom_emu.sv
module serial_rom_emu #(
  parameter int unsigned WORDS  = 64,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              sck_bit,
  input  logic              sdi_bit,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [WORD_W-1:0] load_data,
  output logic              sdo_bit,
  output logic              err_flag
);
  logic              sck_rise;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;

  srom_edge u_edge (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sck_bit(sck_bit), .rise(sck_rise)
  );

  srom_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .ld_en(load_en), .ld_idx(load_idx),
    .ld_data(load_data), .rd_idx(rd_idx), .rd_word(rd_word)
  );

  srom_seq #(.WORDS(WORDS), .WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rise(sck_rise), .sdi(sdi_bit),
    .rd_word(rd_word), .rd_idx(rd_idx), .sdo(sdo_bit), .err(err_flag)
  );

  AST_RISE_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |-> wr_stb); // R1
endmodule

// File: tb/serial_rom_emu_tb.sv
module serial_rom_emu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0, sck_bit = 1'b0, sdi_bit = 1'b0;
  logic        load_en = 1'b0;
  logic [5:0]  load_idx = '0;
  logic [15:0] load_data = '0;
  logic        sdo_bit, err_flag;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model [64];

  always #4 clk = ~clk; // 125 MHz

  serial_rom_emu u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sck_bit(sck_bit), .sdi_bit(sdi_bit),
    .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
    .sdo_bit(sdo_bit), .err_flag(err_flag)
  );

  function automatic logic [15:0] expect_word(input logic [7:0] byte_addr);
    return model[byte_addr[6:1]];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) model[i] = 16'h0000;
    model[0] = 16'hBABA;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_stb = 1'b0; sck_bit = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    model_reset();
  endtask

  task automatic wr(input logic sck, input logic sdi);
    @(negedge clk); wr_stb = 1'b1; sck_bit = sck; sdi_bit = sdi;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    wr(1'b0, b); wr(1'b1, b);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic read_word(input logic [7:0] a, output logic [15:0] w);
    send_byte(8'h03); send_byte(a);
    for (int i = 15; i >= 0; i--) begin
      send_bit(1'($urandom));
      w[i] = sdo_bit;
    end
  endtask

  task automatic preload(input logic [5:0] idx, input logic [15:0] d);
    @(negedge clk); load_en = 1'b1; load_idx = idx; load_data = d;
    @(negedge clk); load_en = 1'b0;
    model[idx] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic        s;
    void'($urandom(32'h1A2B3C4D));
    model_reset();
    do_reset();

    check("R6 reset sdo", 32'(sdo_bit), 0);
    check("R8 reset err", 32'(err_flag), 0);

    // R7: reset contents
    read_word(8'h00, w); check("R7 word0", 32'(w), 32'hBABA);
    read_word(8'h7E, w); check("R7 word63", 32'(w), 0);

    // R4/R5: status then an immediate read
    send_byte(8'h05);
    for (int i = 0; i < 8; i++) begin
      send_bit(1'b1);
      check("R4 status bit", 32'(sdo_bit), 0);
    end
    read_word(8'h01, w); check("R5 read after status", 32'(w), 32'hBABA);

    // R10 preload + R3 low address bit dropped
    preload(6'd5, 16'h8001);
    read_word(8'h0A, w); check("R10 preload read", 32'(w), 32'h8001);
    read_word(8'h0B, w); check("R3 odd addr", 32'(w), 32'h8001);

    // R1: redundant high writes and falling writes between edges
    for (int i = 7; i >= 0; i--) begin
      wr(1'b0, 8'h03 >> i); wr(1'b1, 1'((8'h03 >> i) & 1));
      wr(1'b1, 1'b1); wr(1'b1, 1'b0);
    end
    send_byte(8'h0A);
    for (int i = 15; i >= 0; i--) begin
      send_bit(1'b0);
      w[i] = sdo_bit;
      s = sdo_bit;
      wr(1'b1, 1'b1); wr(1'b0, 1'b1);
      if (i == 8) check("R6 sdo hold", 32'(sdo_bit), 32'(s));
    end
    check("R1 extra writes ignored", 32'(w), 32'h8001);

    // constrained random preloads and reads
    for (int k = 0; k < 40; k++) begin
      preload(6'($urandom_range(0, 63)), 16'($urandom));
    end
    for (int k = 0; k < 60; k++) begin
      logic [7:0] a;
      a = 8'($urandom_range(0, 127));
      read_word(a, w);
      check("R3 random read", 32'(w), 32'(expect_word(a)));
    end
    read_word(8'h7F, w); check("R3 top word", 32'(w), 32'(expect_word(8'h7F)));
    check("R8 no err after reads", 32'(err_flag), 0);

    // R8: unknown code
    send_byte(8'h06);
    check("R8 err raised", 32'(err_flag), 1);
    s = sdo_bit;
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    check("R8 err sticky", 32'(err_flag), 1);
    check("R8 sdo frozen", 32'(sdo_bit), 32'(s));

    // R9: out-of-range word index
    do_reset();
    check("R7 err cleared by reset", 32'(err_flag), 0);
    preload(6'd0, 16'hFFFF);
    read_word(8'h00, w);
    send_byte(8'h03); send_byte(8'h80);
    send_bit(1'b0);
    check("R9 err", 32'(err_flag), 1);
    check("R9 sdo zero", 32'(sdo_bit), 0);

    do_reset();
    read_word(8'h00, w); check("R7 after second reset", 32'(w), 32'hBABA);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule